// File: doc/BRIEF.md
# Supervisory Reset with Bus-Start Watchdog

This block drives the system reset of a CPU supervisor. Two sources feed one reset output. The first is a supply-good level from an external threshold comparator, which arrives already registered. The second is a watchdog that the host must restart from time to time by issuing a start condition on a two-wire serial bus: SDA falls while SCL is high. Reset becomes active as soon as the supply drops. It is released only after the supply has stayed good for a full hold-off interval.

If the watchdog is not restarted in time, it forces the same hold-off reset. After that reset it counts again from zero. Two select bits choose one of three timeout lengths or switch the watchdog off. All lengths are parameters counted in clock ticks.

A build-time parameter sets the polarity of the reset output. A second output, high whenever reset is active and independent of polarity, tells the bus controller to abort the current transfer and tells the nonvolatile write logic not to start a new cycle. The raw SDA and SCL samples pass through a parameterised synchroniser before edge detection.

Top module: `sup_reset_wdog`

## Requirements
- R1: The reset is active out of synchronous reset (`rst_n` low), and after any clock edge that samples `pwr_ok_i` low.
- R2: The reset is released at the HOLD_TICKS-th consecutive rising edge that samples `pwr_ok_i` high. A single low sample restarts the count. With the input raised between edges, the reset therefore stays active for HOLD_TICKS-1 more sampled cycles.
- R3: A watchdog restart is a falling edge of SDA while SCL is high both before and after it, seen after the SYNC_STAGES-deep synchroniser (default 2). A raw fall driven before edge A clears the counter at edge A+2. An SDA rise with SCL high, and an SDA fall with SCL low, have no effect.
- R4: While enabled and not restarted, the watchdog asserts reset after exactly P cycles of deasserted reset. `wd_sel_i` 2'b00 gives P=PER_LONG, 2'b01 gives PER_MID and 2'b10 gives PER_SHORT.
- R5: `wd_sel_i` = 2'b11 disables the watchdog, so reset stays deasserted for as long as the supply is good.
- R6: A watchdog timeout keeps reset active for HOLD_TICKS sampled cycles. The counter then restarts from zero, so the next timeout follows P cycles after release.
- R7: A change of `wd_sel_i` sampled at an edge restarts the counter with the new period. A change at edge E+k after release gives a timeout after k+P_new cycles of deasserted reset.
- R8: With ACTIVE_HIGH=1, `sys_rst_o` is 1 when reset is active. With ACTIVE_HIGH=0, it is 0 when reset is active.
- R9: `bus_abort_o` is 1 exactly while reset is active, whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok_i | input | 1 | Registered supply-above-trip level |
| sda_i | input | 1 | Raw SDA sample |
| scl_i | input | 1 | Raw SCL sample |
| wd_sel_i | input | 2 | Watchdog period select; 2'b11 disables |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| bus_abort_o | output | 1 | Abort bus traffic, block new nonvolatile writes |

## Verification
Each result is due at a fixed cycle:
- A supply drop shows at the output one edge after it is sampled.
- A supply rise releases reset HOLD_TICKS-1 sampled cycles later.
- A bus start clears the counter two edges after the raw fall.
- A period change clears it at the edge that samples the change.
- A timeout holds reset for HOLD_TICKS cycles.

The bench drives inputs on the falling clock edge and samples on the next falling edge. It counts whole sampled cycles of deasserted or asserted reset and compares each count with a value computed from these latencies. It therefore checks the exact cycle of every transition, not a window around it.

// File: rtl/srw_pkg.sv
// Shared types for the supervisory reset block.
// Assumes: two select bits encode three periods plus an off setting.
package srw_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Largest of three tick counts, used to size the watchdog counter.
    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/srw_sync.sv
// Multi-stage synchroniser for asynchronous bus samples.
// Assumes: STAGES >= 2; the reset value matches the idle bus level.
module srw_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // One register stage of the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else if (g == 0) begin
                stage_q[g] <= d_i;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srw_start_det.sv
// Bus start detector: flags an SDA fall while SCL is high on both sides.
// Assumes: inputs are already synchronised to clk; the bus idles high.
module srw_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s_i,
    input  logic scl_s_i,
    output logic start_o
);
    logic sda_d;
    logic scl_d;

    // Delay the synchronised lines by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s_i;
            scl_d <= scl_s_i;
        end
    end

    assign start_o = sda_d & ~sda_s_i & scl_d & scl_s_i;
endmodule

// File: rtl/srw_watchdog.sv
// Watchdog counter with three selectable periods and an off setting.
// Assumes: rst_act_i is the live reset state; the counter is held at zero
// while reset is active and restarts on a bus start or a select change.
module srw_watchdog
    import srw_pkg::*;
#(
    parameter int PER_LONG  = 700,
    parameter int PER_MID   = 300,
    parameter int PER_SHORT = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       start_i,
    input  logic       rst_act_i,
    output logic       expire_o
);
    localparam int CNT_W = $clog2(max_of3(PER_LONG, PER_MID, PER_SHORT) + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_tick;
    logic [1:0]       sel_q;
    logic             enabled;
    logic             restart;

    // Select the final count value of the active period.
    always_comb begin
        case (sel_i)
            WD_LONG:  last_tick = CNT_W'(PER_LONG - 1);
            WD_MID:   last_tick = CNT_W'(PER_MID - 1);
            WD_SHORT: last_tick = CNT_W'(PER_SHORT - 1);
            default:  last_tick = '0;
        endcase
    end

    assign enabled  = (sel_i != WD_OFF);
    assign restart  = rst_act_i | start_i | (sel_i != sel_q) | ~enabled;
    assign expire_o = ~restart & (cnt == last_tick);

    // Track the select bits and advance or clear the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sel_q <= sel_i;
        end else begin
            sel_q <= sel_i;
            if (restart || expire_o) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R6: counter is cleared while the reset is active
    assert_cnt_held_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act_i |=> (cnt == '0));

    // R4: a running counter never passes the selected period
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !rst_act_i && sel_i == sel_q) |-> (cnt <= last_tick));
endmodule

// File: rtl/srw_holdoff.sv
// Reset hold-off timer shared by supply loss and watchdog timeout.
// Assumes: pwr_ok_i is already registered; HOLD_TICKS >= 2.
module srw_holdoff #(
    parameter int HOLD_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok_i,
    input  logic expire_i,
    output logic rst_act_o
);
    localparam int               CNT_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             rst_q;

    // Assert on supply loss or timeout, release after the hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b1;
            cnt   <= '0;
        end else if (!pwr_ok_i || expire_i) begin
            rst_q <= 1'b1;
            cnt   <= '0;
        end else if (rst_q) begin
            if (cnt == LAST) begin
                rst_q <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign rst_act_o = rst_q;

    // R1: a low supply sample forces reset on the next cycle
    assert_rst_on_pwr_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> rst_q);

    // R2: release happens only after a good supply sample
    assert_release_after_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_q) |-> $past(pwr_ok_i));

    // R6: a watchdog timeout turns reset on
    assert_expire_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> rst_q);
endmodule

// File: rtl/sup_reset_wdog.sv
// Supervisory reset top: supply hold-off plus bus-start watchdog.
// Assumes: sda_i/scl_i are asynchronous raw samples; pwr_ok_i is registered.
// sys_rst_o polarity is fixed by ACTIVE_HIGH (R8); bus_abort_o is always
// active high (R9).
module sup_reset_wdog #(
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter int HOLD_TICKS  = 50,
    parameter int PER_LONG    = 700,
    parameter int PER_MID     = 300,
    parameter int PER_SHORT   = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok_i,
    input  logic       sda_i,
    input  logic       scl_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_rst_o,
    output logic       bus_abort_o
);
    logic [1:0] bus_s;
    logic       start;
    logic       expire;
    logic       rst_act;

    srw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (bus_s)
    );

    srw_start_det u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_s_i (bus_s[1]),
        .scl_s_i (bus_s[0]),
        .start_o (start)
    );

    srw_watchdog #(
        .PER_LONG  (PER_LONG),
        .PER_MID   (PER_MID),
        .PER_SHORT (PER_SHORT)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (wd_sel_i),
        .start_i   (start),
        .rst_act_i (rst_act),
        .expire_o  (expire)
    );

    srw_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok_i  (pwr_ok_i),
        .expire_i  (expire),
        .rst_act_o (rst_act)
    );

    if (ACTIVE_HIGH) begin : g_pol_hi
        assign sys_rst_o = rst_act;
    end else begin : g_pol_lo
        assign sys_rst_o = ~rst_act;
    end

    assign bus_abort_o = rst_act;
endmodule

// File: tb/sup_reset_wdog_tb_top.sv
// Self-checking bench: vector table for watchdog timing, then directed tests.
module sup_reset_wdog_tb_top;
    localparam int HOLD  = 50;
    localparam int PLONG = 700;
    localparam int PMID  = 300;
    localparam int PSHRT = 100;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] kind;    // 0 idle, 1 bus start, 2 select change, 3 fall with SCL low
        logic [15:0] at;
        logic [1:0] nsel;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'd0, 16'd0,   2'b00},
        '{2'b01, 2'd0, 16'd0,   2'b01},
        '{2'b10, 2'd0, 16'd0,   2'b10},
        '{2'b10, 2'd1, 16'd60,  2'b10},
        '{2'b01, 2'd1, 16'd250, 2'b01},
        '{2'b00, 2'd2, 16'd40,  2'b10},
        '{2'b10, 2'd3, 16'd50,  2'b10},
        '{2'b10, 2'd2, 16'd30,  2'b01}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       sda = 1'b1;
    logic       scl = 1'b1;
    logic [1:0] wd_sel = 2'b10;
    logic       rst_hi, rst_lo, abort_hi, abort_lo;
    int         checks = 0;
    int         failures = 0;

    always #4 clk = ~clk;

    sup_reset_wdog #(.ACTIVE_HIGH(1'b1), .HOLD_TICKS(HOLD), .PER_LONG(PLONG),
                     .PER_MID(PMID), .PER_SHORT(PSHRT)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .sda_i(sda), .scl_i(scl),
        .wd_sel_i(wd_sel), .sys_rst_o(rst_hi), .bus_abort_o(abort_hi));

    sup_reset_wdog #(.ACTIVE_HIGH(1'b0), .HOLD_TICKS(HOLD), .PER_LONG(PLONG),
                     .PER_MID(PMID), .PER_SHORT(PSHRT)) dut_lo_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .sda_i(sda), .scl_i(scl),
        .wd_sel_i(wd_sel), .sys_rst_o(rst_lo), .bus_abort_o(abort_lo));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input logic [1:0] s);
        case (s)
            2'b00:   return PLONG;
            2'b01:   return PMID;
            default: return PSHRT;
        endcase
    endfunction

    task automatic wait_release();
        for (int g = 0; g < 4000 && rst_hi; g++) @(negedge clk);
    endtask

    // Count sampled cycles of active reset, starting at the current sample.
    task automatic count_active(output int n);
        n = 0;
        while (rst_hi && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n, m, expn;
        // Reset state (R1, R8, R9)
        repeat (3) @(negedge clk);
        check("R1 reset state", rst_hi, 1);
        check("R8 low-polarity reset state", rst_lo, 0);
        check("R9 abort in reset", abort_hi & abort_lo, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 supply low holds reset", rst_hi, 1);

        // Power-up hold-off (R2)
        pwr_ok = 1'b1;
        @(negedge clk);
        count_active(n);
        check("R2 hold-off length", n, HOLD - 1);
        check("R9 abort released", abort_hi, 0);
        check("R8 low-polarity released", rst_lo, 1);

        // Vector table: watchdog timing (R3 R4 R6 R7)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            pwr_ok = 1'b0;
            wd_sel = VECS[i].sel;
            @(negedge clk);
            pwr_ok = 1'b1;
            wait_release();
            n = 1;
            forever begin
                if (n == int'(VECS[i].at) && VECS[i].kind == 2'd1) sda = 1'b0;
                if (n == int'(VECS[i].at) + 1 && VECS[i].kind == 2'd1) sda = 1'b1;
                if (n == int'(VECS[i].at) && VECS[i].kind == 2'd2) wd_sel = VECS[i].nsel;
                if (n == int'(VECS[i].at) && VECS[i].kind == 2'd3) begin scl = 1'b0; sda = 1'b0; end
                if (n == int'(VECS[i].at) + 1 && VECS[i].kind == 2'd3) sda = 1'b1;
                if (n == int'(VECS[i].at) + 2 && VECS[i].kind == 2'd3) scl = 1'b1;
                @(negedge clk);
                if (rst_hi || n > 5000) break;
                n++;
            end
            case (VECS[i].kind)
                2'd1:    expn = int'(VECS[i].at) + 2 + period_of(VECS[i].sel);
                2'd2:    expn = int'(VECS[i].at) + period_of(VECS[i].nsel);
                default: expn = period_of(VECS[i].sel);
            endcase
            if (VECS[i].kind == 2'd1)      check("R3 bus start restarts watchdog", n, expn);
            else if (VECS[i].kind == 2'd2) check("R7 select change restarts", n, expn);
            else if (VECS[i].kind == 2'd3) check("R3 SCL-low fall ignored", n, expn);
            else                           check("R4 timeout period", n, expn);
            check("R8 low-polarity on timeout", rst_lo, 0);
            check("R9 abort on timeout", abort_lo, 1);
            count_active(m);
            check("R6 timeout reset length", m, HOLD);
        end

        // Disabled watchdog (R5)
        @(negedge clk);
        wd_sel = 2'b11;
        wait_release();
        m = 0;
        for (int k = 0; k < PLONG + 100; k++) begin
            @(negedge clk);
            if (rst_hi) m++;
        end
        check("R5 disabled watchdog never fires", m, 0);

        // Supply drop shows after one edge (R1)
        pwr_ok = 1'b0;
        @(negedge clk);
        check("R1 supply drop asserts reset", rst_hi, 1);

        // Dip during hold-off restarts it (R2)
        pwr_ok = 1'b1;
        repeat (20) @(negedge clk);
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        @(negedge clk);
        count_active(n);
        check("R2 dip restarts hold-off", n, HOLD - 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule